// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Flag Register

This block is the arithmetic and logic unit of a small microcoded processor. It combines an accumulator operand with a second operand and produces a result on its output. The second operand may be the data-address value, the program-counter value or the address bus. A one-hot set of function lines chooses the function. The functions are AND, OR, add, subtract, rotate left, rotate right, increment and pass-through. Increment and pass-through step and copy addresses. A compare is the subtract function issued with a flag store, where the microcode does not write the result back.

A three-bit flag register holds carry, zero and data-ready. Each trigger line has its own effect on it. The store trigger latches fresh flags from the current function. The clear trigger resets all three flags. The clear-data trigger resets only the data-ready flag; the microcode issues it together with the jump taken when no data is ready. Flags change on the rising clock edge. The result output is purely combinational.

Top module: `alu8_top`

## Requirements
- R1: After reset is asserted (rst_n low), the carry, zero and data flags read 0.
- R2: Function line bit 0 gives acc AND opb, and bit 1 gives acc OR opb. A store during either leaves the carry flag unchanged.
- R3: Function line bit 2 gives (acc + opb) mod 256. A store during it sets carry to the carry out of bit 7.
- R4: Function line bit 3 gives (acc - opb) mod 256. A store during it sets carry to the borrow, which is 1 when acc < opb. Compare uses this same line, so its result and flags are identical.
- R5: Function line bit 4 gives {acc[6:0], carry} and a store sets carry to acc[7]. Function line bit 5 gives {carry, acc[7:1]} and a store sets carry to acc[0].
- R6: Function line bit 6 gives (opb + 1) mod 256, and bit 7 passes opb unchanged. A store during either leaves carry unchanged.
- R7: On a store with exactly one function line high, the zero flag becomes 1 exactly when the 8-bit result is 0.
- R8: On a store with exactly one function line high and no clear-data, the data flag takes the value of the data-ready input.
- R9: Clear resets all three flags, and it wins over a store in the same cycle.
- R10: Clear-data resets only the data flag. In the same cycle, a store still updates carry and zero.
- R11: When no function line is high, or more than one is, the result is 0 and a store leaves all flags unchanged.
- R12: With no store, clear or clear-data trigger, the flags hold their values whatever the operands and function lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| acc_i | input | 8 | Accumulator operand |
| opb_i | input | 8 | Second operand: data address, program counter or address bus |
| func_i | input | 8 | One-hot function lines: 0 AND, 1 OR, 2 add, 3 subtract, 4 rotate left, 5 rotate right, 6 increment, 7 pass |
| store_i | input | 1 | Latch new flags from the current function |
| clr_all_i | input | 1 | Clear all flags |
| clr_data_i | input | 1 | Clear the data flag only |
| data_rdy_i | input | 1 | External data-ready level, sampled on store |
| res_o | output | 8 | Combinational result |
| carry_o | output | 1 | Carry/borrow flag |
| zero_o | output | 1 | Zero flag |
| data_o | output | 1 | Data-ready flag |

## Verification
A wrong function decode or a wrong carry path is visible on res_o in the same cycle as the stimulus. A flag stored wrongly appears one edge after the trigger. Because rotates feed the carry flag back into the result, a corrupted carry also changes the next rotate's output within one further cycle. A flag register that fails to hold shows as a changed flag after the first idle edge. Invalid function patterns are checked both for a zero result and for untouched flags.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int FUNC_N   = 8;
    localparam int F_AND    = 0;
    localparam int F_OR     = 1;
    localparam int F_ADD    = 2;
    localparam int F_SUB    = 3;
    localparam int F_ROL    = 4;
    localparam int F_ROR    = 5;
    localparam int F_INC    = 6;
    localparam int F_PASS   = 7;

    typedef struct packed {
        logic c;
        logic z;
        logic d;
    } flags_t;
endpackage

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      acc_i,
    input  logic [W-1:0]      opb_i,
    input  logic [FUNC_N-1:0] func_i,
    input  logic              cin_i,
    output logic [W-1:0]      res_o,
    output logic              cout_o,
    output logic              valid_o
);
    logic [W:0] add_w;
    logic [W:0] sub_w;

    always_comb begin
        add_w   = {1'b0, acc_i} + {1'b0, opb_i};
        sub_w   = {1'b0, acc_i} - {1'b0, opb_i};
        valid_o = ($countones(func_i) == 1);
        res_o   = '0;
        cout_o  = cin_i;
        if (valid_o) begin
            if (func_i[F_AND]) begin
                res_o = acc_i & opb_i;
            end else if (func_i[F_OR]) begin
                res_o = acc_i | opb_i;
            end else if (func_i[F_ADD]) begin
                res_o  = add_w[W-1:0];
                cout_o = add_w[W];
            end else if (func_i[F_SUB]) begin
                res_o  = sub_w[W-1:0];
                cout_o = sub_w[W];
            end else if (func_i[F_ROL]) begin
                res_o  = {acc_i[W-2:0], cin_i};
                cout_o = acc_i[W-1];
            end else if (func_i[F_ROR]) begin
                res_o  = {cin_i, acc_i[W-1:1]};
                cout_o = acc_i[0];
            end else if (func_i[F_INC]) begin
                res_o = opb_i + W'(1);
            end else begin
                res_o = opb_i;
            end
        end
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   store_i,
    input  logic   clr_all_i,
    input  logic   clr_data_i,
    input  logic   valid_i,
    input  logic   cout_i,
    input  logic   res_zero_i,
    input  logic   data_rdy_i,
    output flags_t flags_o
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr_all_i) begin
            fl_d = '0;
        end else begin
            if (store_i && valid_i) begin
                fl_d.c = cout_i;
                fl_d.z = res_zero_i;
                fl_d.d = data_rdy_i;
            end
            if (clr_data_i) begin
                fl_d.d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags_o = fl_q;
endmodule

// File: rtl/alu8_top.sv
module alu8_top
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      acc_i,
    input  logic [W-1:0]      opb_i,
    input  logic [FUNC_N-1:0] func_i,
    input  logic              store_i,
    input  logic              clr_all_i,
    input  logic              clr_data_i,
    input  logic              data_rdy_i,
    output logic [W-1:0]      res_o,
    output logic              carry_o,
    output logic              zero_o,
    output logic              data_o
);
    flags_t flags;
    logic   cout;
    logic   valid;

    alu8_core #(.W(W)) u_core (
        .acc_i  (acc_i),
        .opb_i  (opb_i),
        .func_i (func_i),
        .cin_i  (flags.c),
        .res_o  (res_o),
        .cout_o (cout),
        .valid_o(valid)
    );

    alu8_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_i   (store_i),
        .clr_all_i (clr_all_i),
        .clr_data_i(clr_data_i),
        .valid_i   (valid),
        .cout_i    (cout),
        .res_zero_i(res_o == '0),
        .data_rdy_i(data_rdy_i),
        .flags_o   (flags)
    );

    assign carry_o = flags.c;
    assign zero_o  = flags.z;
    assign data_o  = flags.d;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FUNC_N-1:0] func_i,
    input logic              store_i,
    input logic              clr_all_i,
    input logic              clr_data_i,
    input logic              data_rdy_i,
    input logic [W-1:0]      res_o,
    input logic              carry_o,
    input logic              zero_o,
    input logic              data_o
);
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (!carry_o && !zero_o && !data_o));

    a_r10_clear_data: assert property (@(posedge clk) disable iff (!rst_n)
        clr_data_i |=> !data_o);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!store_i && !clr_all_i && !clr_data_i) |=> $stable({carry_o, zero_o, data_o}));

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !clr_all_i && $countones(func_i) == 1) |=> (zero_o == ($past(res_o) == '0)));

    a_r8_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !clr_all_i && !clr_data_i && $countones(func_i) == 1) |=> (data_o == $past(data_rdy_i)));

    a_r11_idle_result: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(func_i) != 1) |-> (res_o == '0));

    a_r11_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (store_i && !clr_all_i && !clr_data_i && $countones(func_i) != 1)
        |=> $stable({carry_o, zero_o, data_o}));
endmodule

bind alu8_top alu8_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_i    (func_i),
    .store_i   (store_i),
    .clr_all_i (clr_all_i),
    .clr_data_i(clr_data_i),
    .data_rdy_i(data_rdy_i),
    .res_o     (res_o),
    .carry_o   (carry_o),
    .zero_o    (zero_o),
    .data_o    (data_o)
);

// File: tb/alu8_top_bench.sv
module alu8_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_i = '0, opb_i = '0, func_i = '0;
    logic       store_i = 1'b0, clr_all_i = 1'b0, clr_data_i = 1'b0, data_rdy_i = 1'b0;
    logic [7:0] res_o;
    logic       carry_o, zero_o, data_o;
    int         n_run = 0, n_fail = 0;

    alu8_top u_alu8_top (
        .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .opb_i(opb_i), .func_i(func_i),
        .store_i(store_i), .clr_all_i(clr_all_i), .clr_data_i(clr_data_i),
        .data_rdy_i(data_rdy_i), .res_o(res_o), .carry_o(carry_o),
        .zero_o(zero_o), .data_o(data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one cycle of stimulus, check the result before the edge and
    // the flags {c,z,d} after it.
    task automatic step(input string tag, input logic [7:0] f, input logic [7:0] a,
                        input logic [7:0] b, input logic st, input logic ca,
                        input logic cd, input logic dr, input logic [7:0] exp_res,
                        input logic [2:0] exp_fl);
        @(negedge clk);
        func_i = f; acc_i = a; opb_i = b;
        store_i = st; clr_all_i = ca; clr_data_i = cd; data_rdy_i = dr;
        #1 chk({tag, " result"}, res_o, exp_res);
        @(negedge clk);
        chk({tag, " flags"}, {5'b0, carry_o, zero_o, data_o}, {5'b0, exp_fl});
        func_i = '0; store_i = 0; clr_all_i = 0; clr_data_i = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset flags", {5'b0, carry_o, zero_o, data_o}, 8'h00);
        chk("R11 idle result", res_o, 8'h00);
    endtask

    task automatic t_logic;
        step("R2 and", 8'h01, 8'hCA, 8'h0F, 1, 0, 0, 0, 8'h0A, 3'b000);
        step("R2 or",  8'h02, 8'hCA, 8'h0F, 1, 0, 0, 0, 8'hCF, 3'b000);
    endtask

    task automatic t_add;
        step("R3 add carry",      8'h04, 8'hF0, 8'h20, 1, 0, 0, 0, 8'h10, 3'b100);
        step("R7 add zero",       8'h04, 8'h80, 8'h80, 1, 0, 0, 0, 8'h00, 3'b110);
        step("R2 and keeps carry",8'h01, 8'hF0, 8'h0F, 1, 0, 0, 0, 8'h00, 3'b110);
    endtask

    task automatic t_sub;
        step("R4 sub borrow", 8'h08, 8'h05, 8'h07, 1, 0, 0, 0, 8'hFE, 3'b100);
        step("R4 cmp equal",  8'h08, 8'h33, 8'h33, 1, 0, 0, 0, 8'h00, 3'b010);
    endtask

    task automatic t_rot;
        step("R3 set carry", 8'h04, 8'hFF, 8'h01, 1, 0, 0, 0, 8'h00, 3'b110);
        step("R5 rol",       8'h10, 8'h01, 8'h00, 1, 0, 0, 0, 8'h03, 3'b000);
        step("R5 rol out",   8'h10, 8'h81, 8'h00, 1, 0, 0, 0, 8'h02, 3'b100);
        step("R5 ror",       8'h20, 8'h02, 8'h00, 1, 0, 0, 0, 8'h81, 3'b000);
    endtask

    task automatic t_incpass;
        step("R6 inc wrap", 8'h40, 8'h00, 8'hFF, 1, 0, 0, 0, 8'h00, 3'b010);
        step("R6 pass",     8'h80, 8'h11, 8'h5A, 1, 0, 0, 0, 8'h5A, 3'b000);
    endtask

    task automatic t_data;
        step("R8 data set",  8'h80, 8'h00, 8'h01, 1, 0, 0, 1, 8'h01, 3'b001);
        step("R10 cld only", 8'h00, 8'h00, 8'h00, 0, 0, 1, 1, 8'h00, 3'b000);
        step("R8 set again", 8'h04, 8'hFF, 8'h01, 1, 0, 0, 1, 8'h00, 3'b111);
        step("R10 cld wins", 8'h04, 8'hFF, 8'h02, 1, 0, 1, 1, 8'h01, 3'b100);
    endtask

    task automatic t_clear;
        step("R8 prep",       8'h04, 8'hFF, 8'h01, 1, 0, 0, 1, 8'h00, 3'b111);
        step("R9 clear wins", 8'h04, 8'hFF, 8'h01, 1, 1, 0, 1, 8'h00, 3'b000);
    endtask

    task automatic t_idle;
        step("R8 prep2",       8'h04, 8'hFF, 8'h01, 1, 0, 0, 1, 8'h00, 3'b111);
        step("R11 no line",    8'h00, 8'h12, 8'h34, 1, 0, 0, 0, 8'h00, 3'b111);
        step("R11 two lines",  8'h0C, 8'h12, 8'h34, 1, 0, 0, 0, 8'h00, 3'b111);
        step("R12 hold",       8'h01, 8'h12, 8'h34, 0, 0, 0, 0, 8'h10, 3'b111);
        step("R12 hold sub",   8'h08, 8'h01, 8'h02, 0, 0, 0, 0, 8'hFF, 3'b111);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_logic();
        t_add();
        t_sub();
        t_rot();
        t_incpass();
        t_data();
        t_clear();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule